// File: doc/BRIEF.md
# Dual-Channel Wiper Register Serial Slave

This block is the digital front end of a two-channel, 256-step digital potentiometer. It sits on a two-wire serial bus as a slave. It runs from a fast system clock that oversamples the bus clock and data lines. The data line is driven only by pulling it low through an open-drain enable.

A write transaction carries three kinds of frame in sequence: the device address, an instruction byte, and one or more data bytes. The instruction byte does four things. It picks a channel, can return that channel's wiper to midscale, sets a shutdown flag, and sets two general-purpose logic outputs. Each data byte that follows overwrites the wiper of the picked channel.

A read transaction has no pointer. Right after the address acknowledge, the slave returns the wiper of whichever channel the most recent instruction byte picked. The two low address bits come from strap pins, so up to four of these slaves can share one bus.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: After reset both wipers read 0x80, the channel select is 0 (first channel), shutdown and both logic outputs are 0, and the data line is released.
- R2: An address byte is accepted only when its upper five bits are 01011 and bits 2:1 equal the strap pins (bit 2 = strap bit 1, bit 1 = strap bit 0). Bit 0 is the direction (1 = read, 0 = write). The slave acknowledges an accepted address, and every byte received in an accepted write, by holding the data line low during the ninth clock.
- R3: On an address mismatch the slave never pulls the data line low until the next START, and bytes that follow change no register.
- R4: The instruction byte, sent MSB first, is decoded as follows. Bit 7 selects the channel (0 = first, 1 = second). Bit 6 requests a midscale reset. Bit 5 is shutdown. Bit 4 is logic output 1. Bit 3 is logic output 2. Bits 2:0 have no effect.
- R5: An instruction with bit 6 set loads 0x80 into the wiper of the channel that the same byte selects.
- R6: Every data byte after the instruction byte in the same write overwrites the selected channel's wiper, and the last one received wins.
- R7: In a read, the byte after the address acknowledge is the selected channel's wiper, sent MSB first. If the master acknowledges it, the slave sends the same value again. If the master does not acknowledge, the slave releases the line until the next START.
- R8: A write that stops after the instruction byte still changes the channel that later reads return.
- R9: A repeated START at any point, including in the middle of a byte, abandons the current transfer and restarts address decoding.
- R10: START is the data line falling while the clock is high, and STOP is the data line rising while the clock is high. Bits clocked after a STOP and before a new START are ignored and not acknowledged.
- R11: Shutdown and both logic outputs change only when an instruction byte is acknowledged. Data bytes and reads leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_pins | input | 2 | Strap levels for address bits 2:1 |
| sda_oe | output | 1 | 1 pulls the data line low |
| wiper_ch1 | output | 8 | First channel wiper register |
| wiper_ch2 | output | 8 | Second channel wiper register |
| chan_sel | output | 1 | Channel picked by the last instruction |
| shutdown | output | 1 | Software shutdown flag |
| out1 | output | 1 | Logic output 1 |
| out2 | output | 1 | Logic output 2 |

## Verification
The bench keeps a behavioural model of the register state and drives complete bus transactions against it. It runs writes to each channel, including a write with several data bytes, and reads with and without a master acknowledge. It also runs a write that ends after the instruction byte, which separates channel selection from data writing. Address mismatches on the strap bits, and bytes clocked with no START, show that ignored traffic leaves the line and the registers untouched. A repeated START cut into the middle of a data byte shows that decoding really restarts. Instructions with the midscale and don't-care bits set separate the reset path from the plain data path.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int WIPER_W = 8;
    localparam int NUM_CH = 2;
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CNT_W = 4;
    localparam logic [4:0] DEV_PREFIX = 5'b01011;
    localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INSTR,
        PH_DATA,
        PH_READ,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic       chan;
        logic       mid;
        logic       sd;
        logic       o1;
        logic       o2;
        logic [2:0] unused;
    } instr_t;

    function automatic logic addr_match(input logic [7:0] b, input logic [1:0] pins);
        return (b[7:3] == DEV_PREFIX) && (b[2:1] == pins);
    endfunction
endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl,
    output logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl       = scl_pipe[STAGES-1];
    assign sda       = sda_pipe[STAGES-1];
    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/dpot_frame_fsm.sv
module dpot_frame_fsm
    import dpot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [1:0]         addr_pins,
    input  logic [WIPER_W-1:0] rd_byte,
    output logic               sda_oe,
    output logic               instr_stb,
    output logic               data_stb,
    output logic [7:0]         rx_byte
);
    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       sh;
    logic [7:0]       tx;
    logic [2:0]       bit_idx;

    always_comb bit_idx = 3'(4'd7 - 4'(cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            sh        <= '0;
            tx        <= '0;
            sda_oe    <= 1'b0;
            instr_stb <= 1'b0;
            data_stb  <= 1'b0;
        end else begin
            instr_stb <= 1'b0;
            data_stb  <= 1'b0;
            if (start_det) begin
                ph     <= PH_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                ph     <= PH_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ph == PH_IDLE || ph == PH_SKIP) begin
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                if (cnt < CNT_W'(8)) sh <= {sh[6:0], sda};
                if (ph == PH_READ && cnt == CNT_W'(8) && sda) ph <= PH_SKIP;
                cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
                if (cnt == CNT_W'(8)) begin
                    case (ph)
                        PH_ADDR: begin
                            if (addr_match(sh, addr_pins)) sda_oe <= 1'b1;
                            else                           ph     <= PH_SKIP;
                        end
                        PH_INSTR: begin
                            sda_oe    <= 1'b1;
                            instr_stb <= 1'b1;
                        end
                        PH_DATA: begin
                            sda_oe   <= 1'b1;
                            data_stb <= 1'b1;
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (cnt == CNT_W'(9)) begin
                    cnt <= '0;
                    case (ph)
                        PH_ADDR: begin
                            if (sh[0]) begin
                                ph     <= PH_READ;
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                ph     <= PH_INSTR;
                                sda_oe <= 1'b0;
                            end
                        end
                        PH_INSTR: begin
                            ph     <= PH_DATA;
                            sda_oe <= 1'b0;
                        end
                        PH_READ: begin
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (ph == PH_READ && cnt != '0) begin
                    sda_oe <= ~tx[bit_idx];
                end
            end
        end
    end

    assign rx_byte = sh;

    // R2: while receiving, the line is pulled only in the acknowledge slot
    assert_ack_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && ph != PH_READ) |-> (cnt >= CNT_W'(8)));

    // R3: an ignored transfer never drives the line
    assert_quiet_skip_R3: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SKIP && $past(ph) == PH_SKIP) |-> !sda_oe);

    // R9: any START restarts address decoding from the first bit
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (ph == PH_ADDR && cnt == '0 && !sda_oe));

    // R10: STOP returns the slave to idle with the line released
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (ph == PH_IDLE && !sda_oe));
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank
    import dpot_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     instr_stb,
    input  logic                     data_stb,
    input  logic [7:0]               rx_byte,
    output logic [NUM_CH*WIPER_W-1:0] wipers,
    output logic                     sel,
    output logic                     sd,
    output logic                     o1,
    output logic                     o2,
    output logic [WIPER_W-1:0]       rd_byte
);
    instr_t ins;
    logic [WIPER_W-1:0] wiper_q [NUM_CH];

    assign ins = instr_t'(rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
            sd  <= 1'b0;
            o1  <= 1'b0;
            o2  <= 1'b0;
        end else if (instr_stb) begin
            sel <= ins.chan;
            sd  <= ins.sd;
            o1  <= ins.o1;
            o2  <= ins.o2;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                wiper_q[c] <= MIDSCALE;
            else if (instr_stb && ins.mid && ins.chan == 1'(c))
                wiper_q[c] <= MIDSCALE;
            else if (data_stb && sel == 1'(c))
                wiper_q[c] <= WIPER_W'(rx_byte);
        end
        assign wipers[c*WIPER_W +: WIPER_W] = wiper_q[c];

        // R6: a wiper moves only after an instruction or data byte
        assert_wiper_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (!instr_stb && !data_stb) |=> $stable(wiper_q[c]));
    end

    assign rd_byte = wiper_q[sel];

    // R11: flags and logic outputs move only on an acknowledged instruction
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !instr_stb |=> $stable({sel, sd, o1, o2}));
endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl
    import dpot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [1:0]          addr_pins,
    output logic                sda_oe,
    output logic [WIPER_W-1:0]  wiper_ch1,
    output logic [WIPER_W-1:0]  wiper_ch2,
    output logic                chan_sel,
    output logic                shutdown,
    output logic                out1,
    output logic                out2
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic instr_stb, data_stb;
    logic [7:0] rx_byte;
    logic [WIPER_W-1:0] rd_byte;
    logic [NUM_CH*WIPER_W-1:0] wipers;

    dpot_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl(scl_s), .sda(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    dpot_frame_fsm u_fsm (
        .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda(sda_s), .start_det(start_det), .stop_det(stop_det),
        .addr_pins(addr_pins), .rd_byte(rd_byte), .sda_oe(sda_oe),
        .instr_stb(instr_stb), .data_stb(data_stb), .rx_byte(rx_byte)
    );

    dpot_wiper_bank u_bank (
        .clk(clk), .rst(rst), .instr_stb(instr_stb), .data_stb(data_stb),
        .rx_byte(rx_byte), .wipers(wipers), .sel(chan_sel), .sd(shutdown),
        .o1(out1), .o2(out2), .rd_byte(rd_byte)
    );

    assign wiper_ch1 = wipers[0 +: WIPER_W];
    assign wiper_ch2 = wipers[WIPER_W +: WIPER_W];

    logic unused_scl;
    assign unused_scl = scl_s;
endmodule

// File: tb/dpot_i2c_ctrl_tb.sv
module dpot_i2c_ctrl_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] pins = 2'b10;
    logic sda_oe, chan_sel, shutdown, out1, out2;
    logic [7:0] wiper_ch1, wiper_ch2;
    wire sda_line = sda_m & ~sda_oe;

    dpot_i2c_ctrl u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .addr_pins(pins), .sda_oe(sda_oe), .wiper_ch1(wiper_ch1),
        .wiper_ch2(wiper_ch2), .chan_sel(chan_sel), .shutdown(shutdown),
        .out1(out1), .out2(out2)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_w [2];
    logic m_sel, m_sd, m_o1, m_o2;
    logic quiet = 1'b0;
    logic quiet_hit = 1'b0;

    always @(negedge clk) if (quiet && sda_oe) quiet_hit <= 1'b1;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "wiper1", 32'(wiper_ch1), 32'(m_w[0]));
        chk(req, "wiper2", 32'(wiper_ch2), 32'(m_w[1]));
        chk(req, "flags", {28'd0, chan_sel, shutdown, out1, out2}, {28'd0, m_sel, m_sd, m_o1, m_o2});
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = ~sda_line;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq();
            v[i] = sda_line;
            wq(); scl_m = 1'b0;
        end
        wq();
        sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] adr(input logic [1:0] p, input logic rd);
        return {5'b01011, p, rd};
    endfunction

    task automatic model_instr(input logic [7:0] ins);
        m_sel = ins[7];
        if (ins[6]) m_w[m_sel] = 8'h80;
        m_sd = ins[5]; m_o1 = ins[4]; m_o2 = ins[3];
    endtask

    task automatic do_write(input string req, input logic [7:0] ins, input int n, input logic [7:0] d0, input logic [7:0] d1);
        logic a;
        bus_start();
        put_byte(adr(pins, 1'b0), a); chk("R2", "write address ack", 32'(a), 32'd1);
        put_byte(ins, a); chk(req, "instruction ack", 32'(a), 32'd1);
        model_instr(ins);
        if (n > 0) begin put_byte(d0, a); chk(req, "data ack", 32'(a), 32'd1); m_w[m_sel] = d0; end
        if (n > 1) begin put_byte(d1, a); chk(req, "data2 ack", 32'(a), 32'd1); m_w[m_sel] = d1; end
        bus_stop();
    endtask

    task automatic do_read(input string req, input int n);
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte(adr(pins, 1'b1), a); chk("R2", "read address ack", 32'(a), 32'd1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, v);
            chk(req, "read data", 32'(v), 32'(m_w[m_sel]));
        end
        bus_stop();
        chk(req, "line released after read", 32'(sda_oe), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        logic a;
        m_w[0] = 8'h80; m_w[1] = 8'h80; m_sel = 0; m_sd = 0; m_o1 = 0; m_o2 = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk_state("R1");
        chk("R1", "sda_oe at reset", 32'(sda_oe), 32'd0);

        // R4 R6 write first channel
        do_write("R6", 8'h00, 1, 8'h3C, 8'h00);
        chk_state("R6");
        // R4 R6 second channel, outputs set, two data bytes
        do_write("R6", 8'h98, 2, 8'h11, 8'hE7);
        chk_state("R4");
        // R7 read selected channel
        do_read("R7", 1);
        chk_state("R11");
        // R8 instruction only, then read the newly selected channel
        do_write("R8", 8'h20, 0, 8'h00, 8'h00);
        chk_state("R8");
        do_read("R8", 1);
        // R5 midscale with don't-care bits set
        do_write("R5", 8'h57, 0, 8'h00, 8'h00);
        chk_state("R5");
        // R7 repeated read with master ack
        do_write("R6", 8'h80, 1, 8'hA5, 8'h00);
        do_read("R7", 2);

        // R3 address mismatch on strap bits
        quiet = 1'b1;
        bus_start();
        put_byte(adr(~pins, 1'b0), a); chk("R3", "mismatch ack", 32'(a), 32'd0);
        put_byte(8'hC8, a); chk("R3", "byte after mismatch ack", 32'(a), 32'd0);
        put_byte(8'h01, a);
        bus_stop();
        // R10 bits without START are ignored
        put_byte(adr(pins, 1'b0), a); chk("R10", "no-start ack", 32'(a), 32'd0);
        put_byte(8'hC8, a);
        put_byte(8'h02, a);
        bus_stop();
        quiet = 1'b0;
        chk("R3", "line never pulled while ignored", 32'(quiet_hit), 32'd0);
        chk_state("R3");

        // R9 repeated START in the middle of a data byte
        bus_start();
        put_byte(adr(pins, 1'b0), a);
        put_byte(8'h00, a);
        model_instr(8'h00);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        put_byte(adr(pins, 1'b0), a); chk("R9", "address after restart ack", 32'(a), 32'd1);
        put_byte(8'h80, a); model_instr(8'h80);
        put_byte(8'h5A, a); m_w[1] = 8'h5A;
        bus_stop();
        chk_state("R9");

        // R2 other strap value
        pins = 2'b01;
        wq();
        do_write("R2", 8'h08, 1, 8'h0F, 8'h00);
        chk_state("R2");
        do_read("R7", 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule